// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter with Level Handshake

This block turns one parallel character into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. When no frame is being sent the line rests high. The bit period comes from an internal divider. Its reload value is derived at elaboration time from the system clock frequency and the baud rate parameters. The defaults are a 100 MHz clock and 19200 baud, which with 8 data bits, no parity and one stop bit gives the common 8N1 link.

The host uses a four-phase level handshake. It puts the character and the frame settings on the inputs and holds `send_req` high. The transmitter accepts the request, raises `busy` and shifts the frame out. It drops `busy` when the last stop bit has ended. The host then drops `send_req`. The transmitter refuses a second character until it has seen `send_req` low. A request that is simply held high therefore never causes a repeated frame. The character and all frame settings are captured in the cycle of acceptance and do not change for the rest of the frame.

Top module: `uart_lvl_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is high and `busy` is low.
- R2: In the clock edge that accepts a request, `busy` rises and `txd` goes low. This start bit lasts exactly one bit period.
- R3: Data bits follow the start bit, least significant bit first. Their count comes from `cfg_len`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Character bits above that count are not sent.
- R4: When `cfg_par_en` is 1, a parity bit follows the last data bit. With `cfg_par_odd` = 0 the number of ones across the data bits and the parity bit is even; with `cfg_par_odd` = 1 it is odd. When `cfg_par_en` is 0 no parity bit is sent.
- R5: The frame ends with high stop bits: one when `cfg_stop2` = 0, two when `cfg_stop2` = 1.
- R6: Every bit of the frame lasts DIV = (CLK_HZ + BAUD/2) / BAUD clock cycles. The defaults give 5208 cycles.
- R7: `busy` falls at the clock edge exactly N*DIV cycles after it rose, where N is the number of bits in the frame. At that edge `txd` is high.
- R8: A new frame is accepted only if `send_req` was sampled low at some edge after the previous acceptance. If `send_req` is held high, `busy` stays low after the frame.
- R9: The character and the frame settings are sampled at acceptance. Changing them while `busy` is high does not alter the frame being sent.
- R10: If `send_req` was dropped during a frame and is high again when `busy` falls, the next frame is accepted one clock later. This leaves exactly one idle-high cycle between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| send_req | input | 1 | Host request, held high until `busy` has fallen |
| tx_char | input | 8 | Character to send; only the low bits set by `cfg_len` are used |
| cfg_len | input | 2 | Data length code: 00=5, 01=6, 10=7, 11=8 bits |
| cfg_par_en | input | 1 | 1 adds a parity bit after the data |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_stop2 | input | 1 | 0 one stop bit, 1 two stop bits |
| busy | output | 1 | High from acceptance until the last stop bit ends |
| txd | output | 1 | Serial line, idle high |

## Verification
Two events can land on the same clock edge: the end of one frame and a host request for the next. In one case `send_req` was dropped during a frame and raised again before it ended, so the re-armed request is pending exactly when `busy` falls. The bench then expects `busy` low for one cycle and the following frame to start with the newly presented character and settings. The opposite case holds `send_req` high across the fall of `busy`, and the bench checks over several bit periods that no frame starts. A third test changes the inputs in the middle of a frame and judges that against the frame contents captured at acceptance.

// File: rtl/uart_tx_pkg.sv
// Package: uart_tx_pkg
// Shared constants, the frame type and the frame builder for the serial
// transmitter. Assumes a data path at most DATA_W bits wide with a minimum
// character length of MIN_DATA bits.
package uart_tx_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_DATA = 5;
    localparam int LEN_W    = 2;
    localparam int FRAME_W  = DATA_W + 4;            // start + data + parity + 2 stop
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] bits;                     // bit 0 goes out first
        logic [CNT_W-1:0]   count;                    // number of bits in the frame
    } frame_t;

    // Assemble the complete serial frame from a character and its settings
    function automatic frame_t build_frame(
        input logic [DATA_W-1:0] ch,
        input logic [LEN_W-1:0]  len_code,
        input logic              par_en,
        input logic              par_odd,
        input logic              stop2
    );
        frame_t f;
        int     n;
        logic   p;
        n      = MIN_DATA + int'(len_code);
        f.bits = '1;
        f.bits[0] = 1'b0;
        p = par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) begin
                f.bits[i + 1] = ch[i];
                p = p ^ ch[i];
            end
        end
        if (par_en) begin
            f.bits[n + 1] = p;
        end
        f.count = CNT_W'(n + 2 + int'(par_en) + int'(stop2));
        return f;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
// Module: uart_baud_gen
// Bit-period divider. A restart pulse reloads it, and while enabled it emits
// one tick every DIV cycles. The first tick comes DIV cycles after the restart.
// Assumes CLK_HZ / BAUD rounds to at least 2.
module uart_baud_gen #(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 19_200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic en,
    output logic tick
);
    localparam int DIV  = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count down one bit period, reloading on restart and on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= RELOAD;
        end else if (en) begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end

    // A tick marks the end of the current bit
    always_comb begin
        tick = en && !restart && (cnt_q == '0);
    end

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD);

    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/uart_tx_hs.sv
// Module: uart_tx_hs
// Host handshake for the transmitter. It issues a one-cycle start when the
// request is high, the transmitter is idle, and the request has been seen low
// since the last start. Assumes busy_i comes from a register.
module uart_tx_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic send_req,
    input  logic busy_i,
    output logic start_o
);
    logic armed_q;

    // Arm when the request is seen low; disarm on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!send_req) begin
            armed_q <= 1'b1;
        end else if (start_o) begin
            armed_q <= 1'b0;
        end
    end

    // Accept a held request only when idle and armed
    always_comb begin
        start_o = send_req && !busy_i && armed_q;
    end

    a_r8_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> $past(send_req));

    a_r8_no_double_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

endmodule

// File: rtl/uart_tx_shift.sv
// Module: uart_tx_shift
// Frame serializer. It loads the assembled frame on start and moves out one
// bit per tick. It goes idle after the last bit and drives the line from bit 0
// of its shift register. Assumes start arrives only while idle.
module uart_tx_shift
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [DATA_W-1:0] ch,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    output logic              active_o,
    output logic              txd_o
);
    frame_t             next_frame;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;
    logic               active_q;

    // Build the frame from the inputs present at acceptance
    always_comb begin
        next_frame = build_frame(ch, len_code, par_en, par_odd, stop2);
    end

    // Load on start, shift on tick, and return to all-ones idle after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '1;
            left_q   <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            sh_q     <= next_frame.bits;
            left_q   <= next_frame.count;
            active_q <= 1'b1;
        end else if (tick) begin
            if (left_q == CNT_W'(1)) begin
                sh_q     <= '1;
                left_q   <= '0;
                active_q <= 1'b0;
            end else begin
                sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                left_q <= left_q - 1'b1;
            end
        end
    end

    // Drive the outputs from state
    always_comb begin
        active_o = active_q;
        txd_o    = sh_q[0];
    end

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> txd_o);

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> !txd_o);

    a_r7_end_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> $past(txd_o));

    a_r9_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !tick) |=> $stable(sh_q));

endmodule

// File: rtl/uart_lvl_tx.sv
// Module: uart_lvl_tx
// Top of the asynchronous serial transmitter with a four-phase level
// handshake. It joins the handshake, the bit-period divider and the frame
// serializer. Assumes the host keeps the inputs steady while send_req is high
// and busy is low.
module uart_lvl_tx
    import uart_tx_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 19_200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    input  logic [DATA_W-1:0] tx_char,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    output logic              busy,
    output logic              txd
);
    logic start;
    logic tick;
    logic active;

    uart_tx_hs u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .send_req (send_req),
        .busy_i   (active),
        .start_o  (start)
    );

    uart_baud_gen #(
        .CLK_HZ (CLK_HZ),
        .BAUD   (BAUD)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .en      (active),
        .tick    (tick)
    );

    uart_tx_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .ch       (tx_char),
        .len_code (cfg_len),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .stop2    (cfg_stop2),
        .active_o (active),
        .txd_o    (txd)
    );

    // Busy is the serializer's activity flag
    always_comb begin
        busy = active;
    end

    a_r7_busy_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> txd);

endmodule

// File: tb/uart_lvl_tx_tb.sv
module uart_lvl_tx_tb;
    localparam int CLK_HZ = 100_000_000;
    localparam int BAUD   = 12_500_000;
    localparam int DIV    = (CLK_HZ + BAUD / 2) / BAUD;

    typedef struct {
        logic [11:0] bits;
        int          n;
        int          nd;
        bit          pe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send_req = 1'b0;
    logic [7:0] tx_char = 8'h00;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       busy;
    logic       txd;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    uart_lvl_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .tx_char(tx_char),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .busy(busy), .txd(txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    // Expected frame, built from the requirement text
    function automatic exp_t make_exp(input logic [7:0] d, input logic [1:0] len,
                                      input bit pe, input bit po, input bit s2);
        exp_t e;
        int   k;
        bit   ones;
        e.nd = 5 + int'(len);
        e.pe = pe;
        e.bits = '1;
        e.bits[0] = 1'b0;
        ones = 1'b0;
        for (int i = 0; i < e.nd; i++) begin
            e.bits[1 + i] = d[i];
            ones ^= d[i];
        end
        k = 1 + e.nd;
        if (pe) begin
            e.bits[k] = po ? ~ones : ones;
            k++;
        end
        e.n = k + 1 + int'(s2);
        return e;
    endfunction

    task automatic present(input logic [7:0] d, input logic [1:0] len,
                           input bit pe, input bit po, input bit s2);
        tx_char = d; cfg_len = len; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
        exp_q.push_back(make_exp(d, len, pe, po, s2));
    endtask

    // Driver: one full four-phase transaction
    task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                              input bit pe, input bit po, input bit s2,
                              input bit scramble_mid, input bit hold_after);
        @(negedge clk);
        present(d, len, pe, po, s2);
        send_req = 1'b1;
        while (!busy) @(negedge clk);
        if (scramble_mid) begin
            repeat (2 * DIV) @(negedge clk);
            tx_char = ~d; cfg_len = ~len; cfg_par_en = ~pe; cfg_par_odd = ~po; cfg_stop2 = ~s2;
        end
        while (busy) @(negedge clk);
        if (hold_after) begin
            for (int c = 0; c < 3 * DIV; c++) begin
                @(negedge clk);
                if (busy) break;
            end
            check(!busy && txd, "R8 held request restarted", int'(busy), 0);
        end
        send_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pop the expected frame at each busy rise and compare bit centres
    initial begin
        exp_t e;
        string tag;
        forever begin
            @(negedge clk);
            if (rst_n && busy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected frame", 1, 0);
                    while (busy) @(negedge clk);
                end else begin
                    e = exp_q.pop_front();
                    repeat (DIV / 2) @(negedge clk);
                    for (int k = 0; k < e.n; k++) begin
                        if (k > 0) repeat (DIV) @(negedge clk);
                        if (k == 0) tag = "R2 start bit";
                        else if (k <= e.nd) tag = "R3 data bit";
                        else if (e.pe && k == e.nd + 1) tag = "R4 parity bit";
                        else tag = "R5 stop bit";
                        check(txd === e.bits[k], tag, int'(txd), int'(e.bits[k]));
                    end
                    repeat (DIV / 2 - 1) @(negedge clk);
                    check(busy === 1'b1, "R6 bit period busy before end", int'(busy), 1);
                    @(negedge clk);
                    check(busy === 1'b0 && txd === 1'b1, "R7 busy fall at frame end",
                          int'(busy), 0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0, "R1 reset idle", int'(txd), 1);

        send_frame(8'h57, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // R3 8N1
        send_frame(8'hF3, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // R4 even, 5 bits
        send_frame(8'h2D, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);   // R4 odd, R5 two stop
        send_frame(8'hA5, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);   // R3 6 bits
        send_frame(8'h3C, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);   // R9 mid-frame changes
        send_frame(8'h81, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);   // R8 held request
        check(busy === 1'b0 && txd === 1'b1, "R1 idle between frames", int'(busy), 0);

        // R10: drop then re-raise during a frame; next frame follows with one idle cycle
        @(negedge clk);
        present(8'h6E, 2'b11, 1'b1, 1'b1, 1'b0);
        send_req = 1'b1;
        while (!busy) @(negedge clk);
        repeat (DIV) @(negedge clk);
        send_req = 1'b0;
        repeat (DIV) @(negedge clk);
        present(8'h19, 2'b10, 1'b0, 1'b0, 1'b1);
        send_req = 1'b1;
        while (busy) @(negedge clk);
        check(busy === 1'b0 && txd === 1'b1, "R10 one idle cycle", int'(busy), 0);
        @(negedge clk);
        check(busy === 1'b1 && txd === 1'b0, "R10 next frame starts", int'(busy), 1);
        while (busy) @(negedge clk);
        send_req = 1'b0;
        repeat (4 * DIV) @(negedge clk);
        check(exp_q.size() == 0, "R8 all frames sent", exp_q.size(), 0);
        check(busy === 1'b0 && txd === 1'b1, "R1 final idle", int'(txd), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule